// File: doc/BRIEF.md
# Signaling PCM Stream Formatter

The formatter turns a per-channel table of received signaling bits into a serial stream with one bit per backplane clock, aligned to the backplane channel timing. Each timeslot carries eight bits. The upper four bits are always zero. The channel's signaling nibble goes into the lower four bits, sent first-bit-first. A signaling extractor upstream writes fresh four-bit values into a staging table at any time. The values that go out on the line come from a separate active table. That table takes over the staging contents only when a multiframe ends, and not at all while the freeze input is high. Downstream logic therefore sees signaling that changes once per multiframe and never partway through one.

Three line formats are supported, each with its own multiframe length. T1 extended superframe carries ABCD and has 24 frames. T1 superframe carries AB, which is sent twice in the nibble, and has 12 frames. E1 channel-associated signaling carries ABCD and has 16 frames. A T1 stream can be placed on a 1.544 MHz backplane, which has 193 bits per frame, or on a 2.048 MHz backplane, which has 256 bits per frame. E1 always uses 256 bits per frame. A frame pulse marks the first bit of each frame. A multiframe pulse, given together with a frame pulse, forces a multiframe boundary.

Top module: `sig_pcm_formatter`

## Requirements
- R1: `sig_out` is 0 during reset and stays 0 until the first `fsync` has been sampled. The first sampled `fsync` starts framing.
- R2: When `fsync` is sampled high on an edge, `sig_out` after that edge carries frame bit position 0. Each later edge moves to the next position. The frame has 193 positions when `mode` is T1 (00, 01 or 11) with `bp_2m`=0, and 256 positions otherwise. Framing wraps to position 0 after the last position even without `fsync`. In the 193-bit frame, position 0 is an overhead bit driven 0, and timeslot n occupies positions 1+8n to 8+8n. In the 256-bit frame, timeslot n occupies positions 8n to 8n+7.
- R3: The first four bits of every timeslot are driven 0.
- R4: In modes 00 (T1 ABCD, also used for reserved code 11) and 10 (E1), the last four bits of a timeslot carry the active nibble of that channel from bit 3 down to bit 0. Bit 3 is A and bit 0 is D.
- R5: In mode 01 (T1 AB), the last four bits of a timeslot are A, B, A, B, taken from bits 3 and 2 of the active nibble.
- R6: A write (`wr_en`, `wr_chan`, `wr_sig`) changes only the staging table. The active table copies the whole staging table on the edge of an `fsync` that starts a new multiframe. A new multiframe starts after 24 frames in mode 00/11, after 12 in mode 01 and after 16 in mode 10, counted in `fsync` pulses. A write on the copy edge is not part of that copy.
- R7: While `freeze` is high on a boundary edge, the active table keeps its values, and the stream keeps showing the old nibbles.
- R8: In T1 modes on the 2.048 MHz backplane, timeslots 24 to 31 are all zeros.
- R9: In E1 mode, timeslots 0 and 16 are all zeros.
- R10: `mfsync` sampled high together with `fsync` forces a multiframe boundary and restarts the frame count at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame pulse; marks position 0 of a frame |
| mfsync | input | 1 | Multiframe pulse, valid only with `fsync` |
| freeze | input | 1 | Holds the active table at boundaries |
| mode | input | 2 | 00 T1 ABCD, 01 T1 AB, 10 E1, 11 same as 00 |
| bp_2m | input | 1 | 1 = 2.048 MHz backplane for T1 |
| wr_en | input | 1 | Staging write strobe |
| wr_chan | input | 5 | Channel/timeslot index for the write |
| wr_sig | input | 4 | Signaling nibble, bit 3 = A |
| sig_out | output | 1 | Serial signaling stream |

## Verification
The assertions check on every cycle the rules that follow from a single cycle's timing. Reserved bits, idle timeslots and unsynchronised periods must stay zero. The active table may change only on a boundary that is not frozen, and when it changes it must equal the staging contents. A boundary must come from a frame pulse, and a multiframe pulse must force one. A repeated AB pair in the T1 AB mode must match itself. The assertions cannot show that a boundary falls on the right frame count for each mode, or that a nibble appears in the right timeslot in the right bit order. Those need the bench, which keeps its own model of the two tables and the frame counter and compares every output bit over several multiframes of random writes. Its scenarios cover each mode and backplane, a freeze held across a boundary, and a realignment in the middle of a multiframe.

// File: rtl/sigfmt_pkg.sv
package sigfmt_pkg;

  typedef enum logic [1:0] {
    MODE_T1_ABCD = 2'b00,
    MODE_T1_AB   = 2'b01,
    MODE_E1      = 2'b10,
    MODE_RSVD    = 2'b11
  } sig_mode_e;

  localparam int SLOT_BITS      = 8;
  localparam int BIT_IDX_W      = $clog2(SLOT_BITS);
  localparam int T1_CHANNELS    = 24;
  localparam int T1_FRAME_BITS  = T1_CHANNELS * SLOT_BITS + 1;
  localparam int WIDE_SLOTS     = 32;
  localparam int WIDE_FRAME_BITS = WIDE_SLOTS * SLOT_BITS;
  localparam int E1_CAS_SLOT    = 16;
  localparam int MF_T1_ABCD     = 24;
  localparam int MF_T1_AB       = 12;
  localparam int MF_E1          = 16;
  localparam int MAX_MF_FRAMES  = 24;

  function automatic logic is_t1(sig_mode_e m);
    return m != MODE_E1;
  endfunction

  // Number of bit positions per frame for a mode and backplane rate.
  function automatic int frame_bits(sig_mode_e m, logic wide);
    if (is_t1(m) && !wide) return T1_FRAME_BITS;
    return WIDE_FRAME_BITS;
  endfunction

  // Frames per multiframe.
  function automatic int mf_frames(sig_mode_e m);
    case (m)
      MODE_T1_AB: return MF_T1_AB;
      MODE_E1:    return MF_E1;
      default:    return MF_T1_ABCD;
    endcase
  endfunction

  // Whether a timeslot carries a signaling nibble at all.
  function automatic logic slot_carries(sig_mode_e m, int slot);
    if (m == MODE_E1) return (slot != 0) && (slot != E1_CAS_SLOT);
    return slot < T1_CHANNELS;
  endfunction

  // Lower-nibble image sent on the line, MSB first.
  function automatic logic [3:0] format_nibble(sig_mode_e m, logic [3:0] sig);
    if (m == MODE_T1_AB) return {sig[3], sig[2], sig[3], sig[2]};
    return sig;
  endfunction

endpackage

// File: rtl/sigfmt_timing.sv
module sigfmt_timing
  import sigfmt_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int FCNT_W = 5,
  localparam int POS_W = SLOT_W + BIT_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fsync,
  input  logic                 mfsync,
  input  logic                 freeze,
  input  sig_mode_e            mode,
  input  logic                 bp_2m,
  output logic [SLOT_W-1:0]    slot_nxt,
  output logic [BIT_IDX_W-1:0] bit_nxt,
  output logic                 fbit_nxt,
  output logic                 synced_nxt,
  output logic                 commit
);

  logic [POS_W-1:0]  pos_q, pos_nxt, off;
  logic [FCNT_W-1:0] fcnt_q;
  logic              synced_q;
  logic              narrow;
  logic              mf_boundary;

  assign narrow = is_t1(mode) && !bp_2m;

  always_comb begin
    if (fsync || int'(pos_q) >= frame_bits(mode, bp_2m) - 1) pos_nxt = '0;
    else pos_nxt = pos_q + 1'b1;
  end

  assign fbit_nxt   = narrow && (pos_nxt == '0);
  assign off        = narrow ? pos_nxt - 1'b1 : pos_nxt;
  assign slot_nxt   = off[POS_W-1:BIT_IDX_W];
  assign bit_nxt    = off[BIT_IDX_W-1:0];
  assign synced_nxt = synced_q | fsync;

  assign mf_boundary = mfsync || (int'(fcnt_q) >= mf_frames(mode) - 1);
  assign commit      = fsync && mf_boundary && !freeze;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= '0;
      synced_q <= 1'b0;
      fcnt_q   <= '0;
    end else begin
      pos_q    <= pos_nxt;
      synced_q <= synced_nxt;
      if (fsync) fcnt_q <= mf_boundary ? '0 : fcnt_q + 1'b1;
    end
  end

  a_r2_fsync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (pos_q == '0));
  a_r6_commit_framed: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> fsync);
  a_r7_freeze_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !commit);
  a_r10_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && mfsync && !freeze) |-> commit);

endmodule

// File: rtl/sigfmt_buffer.sv
module sigfmt_buffer
  import sigfmt_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SIG_BITS  = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_chan,
  input  logic [SIG_BITS-1:0] wr_sig,
  input  logic                commit,
  input  logic [SLOT_W-1:0]   rd_slot,
  output logic [SIG_BITS-1:0] rd_sig
);

  logic [NUM_SLOTS-1:0][SIG_BITS-1:0] stg_q;
  logic [NUM_SLOTS-1:0][SIG_BITS-1:0] act_q;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chan
    logic hit;
    assign hit = wr_en && (int'(wr_chan) == i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_q[i] <= '0;
        act_q[i] <= '0;
      end else begin
        if (hit)    stg_q[i] <= wr_sig;
        if (commit) act_q[i] <= stg_q[i];
      end
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_q[i]));
    a_r6_copy: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (act_q[i] == $past(stg_q[i])));
  end

  assign rd_sig = act_q[rd_slot];

endmodule

// File: rtl/sigfmt_serializer.sv
module sigfmt_serializer
  import sigfmt_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int SIG_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sig_mode_e            mode,
  input  logic [SLOT_W-1:0]    slot_nxt,
  input  logic [BIT_IDX_W-1:0] bit_nxt,
  input  logic                 fbit_nxt,
  input  logic                 synced_nxt,
  input  logic [SIG_BITS-1:0]  rd_sig,
  output logic                 sig_out
);

  logic       live;
  logic [3:0] nib;
  logic       bit_val;
  logic       sig_q;

  // observation registers for the checks below
  logic [BIT_IDX_W-1:0] bit_q;
  logic [SLOT_W-1:0]    slot_q;
  logic                 live_q;
  logic                 d4_q;

  assign live    = synced_nxt && !fbit_nxt && slot_carries(mode, int'(slot_nxt));
  assign nib     = format_nibble(mode, rd_sig);
  assign bit_val = (live && bit_nxt[2]) ? nib[~bit_nxt[1:0]] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
      live_q <= 1'b0;
      d4_q   <= 1'b0;
    end else begin
      sig_q  <= bit_val;
      bit_q  <= bit_nxt;
      slot_q <= slot_nxt;
      live_q <= live;
      d4_q   <= (mode == MODE_T1_AB);
    end
  end

  assign sig_out = sig_q;

  a_r1_unsynced_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_nxt |=> !sig_out);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_nxt[2] |=> !sig_out);
  a_r8_t1_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (is_t1(mode) && !fbit_nxt && int'(slot_nxt) >= T1_CHANNELS) |=> !sig_out);
  a_r9_e1_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_E1 && (slot_nxt == '0 || int'(slot_nxt) == E1_CAS_SLOT)) |=> !sig_out);
  a_r5_ab_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q == 3'd6 && live_q && d4_q && $past(d4_q) && $past(d4_q, 2) &&
     $past(live_q, 2) && $past(bit_q, 2) == 3'd4 && $past(slot_q, 2) == slot_q)
    |-> (sig_out == $past(sig_out, 2)));

endmodule

// File: rtl/sig_pcm_formatter.sv
module sig_pcm_formatter
  import sigfmt_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SIG_BITS  = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int FCNT_W   = $clog2(MAX_MF_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              mfsync,
  input  logic              freeze,
  input  logic [1:0]        mode,
  input  logic              bp_2m,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_chan,
  input  logic [SIG_BITS-1:0] wr_sig,
  output logic              sig_out
);

  sig_mode_e            mode_e;
  logic [SLOT_W-1:0]    slot_nxt;
  logic [BIT_IDX_W-1:0] bit_nxt;
  logic                 fbit_nxt;
  logic                 synced_nxt;
  logic                 commit;
  logic [SIG_BITS-1:0]  rd_sig;

  assign mode_e = sig_mode_e'(mode);

  sigfmt_timing #(.SLOT_W(SLOT_W), .FCNT_W(FCNT_W)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .mfsync     (mfsync),
    .freeze     (freeze),
    .mode       (mode_e),
    .bp_2m      (bp_2m),
    .slot_nxt   (slot_nxt),
    .bit_nxt    (bit_nxt),
    .fbit_nxt   (fbit_nxt),
    .synced_nxt (synced_nxt),
    .commit     (commit)
  );

  sigfmt_buffer #(.NUM_SLOTS(NUM_SLOTS), .SIG_BITS(SIG_BITS)) u_buffer (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_chan (wr_chan),
    .wr_sig  (wr_sig),
    .commit  (commit),
    .rd_slot (slot_nxt),
    .rd_sig  (rd_sig)
  );

  sigfmt_serializer #(.SLOT_W(SLOT_W), .SIG_BITS(SIG_BITS)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_e),
    .slot_nxt   (slot_nxt),
    .bit_nxt    (bit_nxt),
    .fbit_nxt   (fbit_nxt),
    .synced_nxt (synced_nxt),
    .rd_sig     (rd_sig),
    .sig_out    (sig_out)
  );

endmodule

// File: tb/tb_sig_pcm_formatter.sv
`timescale 1ns/1ps
module tb_sig_pcm_formatter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0, mfsync = 1'b0, freeze = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       bp_2m = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_chan = '0;
  logic [3:0] wr_sig = '0;
  logic       sig_out;

  int checks = 0, fails = 0;
  string scen = "";
  logic [3:0] stg [32];
  logic [3:0] act [32];
  int  fcnt = 0;
  bit  have_prev = 0;
  bit  prev_exp;
  string prev_tag;
  int  prev_pos;

  always #2.5 clk = ~clk;

  sig_pcm_formatter dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .mfsync(mfsync), .freeze(freeze),
    .mode(mode), .bp_2m(bp_2m), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_sig(wr_sig), .sig_out(sig_out)
  );

  function automatic int frame_len_m(int m, bit wide);
    return (m != 2 && !wide) ? 193 : 256;
  endfunction

  function automatic int mf_len_m(int m);
    if (m == 1) return 12;
    if (m == 2) return 16;
    return 24;
  endfunction

  // expected line bit at frame position p, and the requirement it falls under
  function automatic bit exp_bit(int m, bit wide, int p, output string tag);
    int off, slot, b;
    bit t1n;
    t1n = (m != 2) && !wide;
    if (t1n && p == 0) begin tag = "R2"; return 0; end
    off  = t1n ? p - 1 : p;
    slot = off / 8;
    b    = off % 8;
    if (b < 4) begin tag = "R3"; return 0; end
    if (m != 2 && slot >= 24) begin tag = "R8"; return 0; end
    if (m == 2 && (slot == 0 || slot == 16)) begin tag = "R9"; return 0; end
    if (m == 1) begin tag = "R5"; return act[slot][((b - 4) % 2 == 0) ? 3 : 2]; end
    tag = "R4";
    return act[slot][7 - b];
  endfunction

  task automatic check_bit(bit e, string tag, int p);
    checks++;
    if (sig_out !== e) begin
      fails++;
      $display("FAIL %s/%s pos %0d got %b exp %b", tag, scen, p, sig_out, e);
    end
  endtask

  task automatic run_frames(int nframes, bit mf_first);
    for (int f = 0; f < nframes; f++) begin
      int flen;
      flen = frame_len_m(int'(mode), bp_2m);
      for (int p = 0; p < flen; p++) begin
        string t;
        bit e;
        @(negedge clk);
        if (have_prev) check_bit(prev_exp, prev_tag, prev_pos);
        fsync  = (p == 0);
        mfsync = (p == 0) && (f == 0) && mf_first;
        if (p == 0) begin
          bit bnd;
          bnd  = mfsync || (fcnt >= mf_len_m(int'(mode)) - 1);
          fcnt = bnd ? 0 : fcnt + 1;
          if (bnd && !freeze) for (int c = 0; c < 32; c++) act[c] = stg[c];
        end
        e = exp_bit(int'(mode), bp_2m, p, t);
        wr_en   = ($urandom % 4) == 0;
        wr_chan = 5'($urandom % 32);
        wr_sig  = 4'($urandom % 16);
        if (wr_en) stg[wr_chan] = wr_sig;
        prev_exp = e; prev_tag = t; prev_pos = p; have_prev = 1;
      end
    end
    @(negedge clk);
    check_bit(prev_exp, prev_tag, prev_pos);
    have_prev = 0;
    fsync = 0; mfsync = 0; wr_en = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int c = 0; c < 32; c++) begin stg[c] = '0; act[c] = '0; end
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (sig_out !== 1'b0) begin fails++; $display("FAIL R1 in reset got %b exp 0", sig_out); end
    end
    @(negedge clk) rst_n = 1'b1;
    // R1: no framing yet, writes must not reach the line
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_chan = 5'(i % 32); wr_sig = 4'hF;
      stg[i % 32] = 4'hF;
      checks++;
      if (sig_out !== 1'b0) begin fails++; $display("FAIL R1 unsynced got %b exp 0", sig_out); end
    end
    wr_en = 1'b0;

    scen = "R6"; mode = 2'b00; bp_2m = 0; run_frames(50, 1);
    scen = "R6"; mode = 2'b01; bp_2m = 0; run_frames(36, 1);
    scen = "R7"; mode = 2'b00; bp_2m = 0; freeze = 1; run_frames(30, 1);
    freeze = 0; run_frames(24, 0);
    scen = "R9"; mode = 2'b10; run_frames(33, 1);
    scen = "R8"; mode = 2'b00; bp_2m = 1; run_frames(25, 1);
    scen = "R8"; mode = 2'b01; bp_2m = 1; run_frames(13, 1);
    scen = "R10"; mode = 2'b10; bp_2m = 0; run_frames(5, 1);
    run_frames(17, 1);
    scen = "R4"; mode = 2'b11; bp_2m = 0; run_frames(25, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule